// File: doc/BRIEF.md
# Dual-Role SPI Byte Engine

This block moves one byte at a time over a four-wire serial link, in both directions at once. A single mode input picks its role. As bus master it makes the serial clock from the system clock through a power-of-two divider. It starts a byte as soon as the host writes the data port while no byte is in flight. As bus slave it takes clock and an active-low select from an outside master and shifts only while that select is low.

Both roles use one shift register. Its top bit feeds the outgoing line, and bits arriving on the opposite line enter at the bottom. After the eighth serial clock the received byte is copied into a read buffer, and a completion flag rises in the same cycle. The host clears the flag by reading status while the flag is set and then reading the data port. A write that arrives while a byte is active is dropped and marked by a sticky collision bit.

Top module: `spi_dual_role`

## Requirements
- R1: With `is_master`=1 the block drives the serial clock (`sck_oe`=1). With `is_master`=0, `sck_oe`=0 and the block takes its clock from `sck_i`.
- R2: In master mode, a `wr_en` pulse while idle loads `wr_data` into the shift register and starts a byte. From the next cycle `mosi_o` shows bit 7 of that byte.
- R3: The master serial clock idles low. Each of its phases lasts 2^`div_sel` system clocks, so SCK = clk / 2^(`div_sel`+1). Values of `div_sel` above 4 act as 4.
- R4: Outgoing data changes only on the falling SCK edge and is sampled on the rising edge, most significant bit first, in both directions at the same time.
- R5: The completion flag `done_flag` sets on the eighth falling SCK edge. In the same cycle, `rd_data` takes the byte received on the opposite line.
- R6: `rd_data` keeps its value until the next completed byte replaces it.
- R7: `done_flag` clears only when a `stat_rd` pulse seen while the flag is set is followed later by an `rd_en` pulse. An `rd_en` with no status read first leaves the flag set.
- R8: A `wr_en` while a byte is active (master busy, or slave select low) does not change the byte being shifted and sets the sticky `wcol_flag`. The same status-then-data read sequence clears `wcol_flag`.
- R9: In slave mode, `sck_i` edges are ignored while `ss_n` is high. With `ss_n` low the slave shifts in from `mosi_i` and out on `miso_o`. Each SCK phase must last at least four system clocks.
- R10: If `ss_n` rises in the middle of a slave byte, the partial byte is dropped, the bit count restarts, and `done_flag` and `rd_data` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| div_sel | input | 3 | Master clock divider select |
| wr_en | input | 1 | Data port write strobe |
| wr_data | input | 8 | Byte to transmit |
| stat_rd | input | 1 | Status read strobe |
| rd_en | input | 1 | Data port read strobe |
| rd_data | output | 8 | Read buffer (last received byte) |
| done_flag | output | 1 | Byte-complete flag |
| wcol_flag | output | 1 | Sticky write-collision flag |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| ss_n | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Master-out line, slave side |
| mosi_o | output | 1 | Master-out line, master side |
| miso_i | input | 1 | Master-in line, master side |
| miso_o | output | 1 | Master-in line, slave side |
| miso_oe | output | 1 | Slave output enable (selected) |

## Verification
The properties assume the mode input does not change while a byte is in flight. They also assume that in slave mode the outside clock and select obey the four-cycle minimum phase. The stimulus changes `is_master` only between transfers. The bench's own master drives slave-mode phases of four to six system clocks. Random stimulus covers data bytes and divider settings. Directed cases cover the mid-byte select release, writes during a transfer, and a data read with no status read first.

// File: rtl/spi_dual_role.sv
module spi_dual_role #(
  parameter int DW     = 8,
  parameter int MAXDIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_master,
  input  logic [2:0]    div_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          stat_rd,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          done_flag,
  output logic          wcol_flag,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          ss_n,
  input  logic          mosi_i,
  output logic          mosi_o,
  input  logic          miso_i,
  output logic          miso_o,
  output logic          miso_oe
);
  localparam int CW = $clog2(DW);
  localparam int TW = MAXDIV + 1;

  logic [DW-1:0] sh, rxbuf;
  logic [CW-1:0] bits;
  logic [TW-1:0] tmr;
  logic [2:0]    sck_s, ss_s;
  logic [1:0]    mosi_s;
  logic          samp, busy, sck_q, armed;

  wire [2:0]    ds      = (div_sel > 3'(MAXDIV)) ? 3'(MAXDIV) : div_sel;
  wire [TW-1:0] half    = TW'(1) << ds;
  wire          m_tick  = busy && (tmr == half - TW'(1));
  wire          s_rise  = sck_s[1] & ~sck_s[2];
  wire          s_fall  = ~sck_s[1] & sck_s[2];
  wire          ss_low  = ~ss_s[1];
  wire          active  = is_master ? busy : ss_low;
  wire          load    = wr_en && !active;
  wire          samp_ev = is_master ? (m_tick && !sck_q) : (ss_low && s_rise);
  wire          shft_ev = is_master ? (m_tick && sck_q)  : (ss_low && s_fall);
  wire          in_bit  = is_master ? miso_i : mosi_s[1];
  wire          last    = shft_ev && (bits == CW'(DW-1));
  wire          clr     = rd_en && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; rxbuf <= '0; bits <= '0; tmr <= '0;
      sck_s <= '0; ss_s <= '1; mosi_s <= '0;
      samp <= 1'b0; busy <= 1'b0; sck_q <= 1'b0;
      done_flag <= 1'b0; wcol_flag <= 1'b0; armed <= 1'b0;
    end else begin
      sck_s  <= {sck_s[1:0], sck_i};
      ss_s   <= {ss_s[1:0], ss_n};
      mosi_s <= {mosi_s[0], mosi_i};

      if (busy) begin
        tmr <= m_tick ? '0 : tmr + TW'(1);
        if (m_tick) sck_q <= ~sck_q;
      end
      if (samp_ev) samp <= in_bit;

      if (load) begin
        sh    <= wr_data;
        bits  <= '0;
        busy  <= is_master;
        tmr   <= '0;
        sck_q <= 1'b0;
      end else if (shft_ev) begin
        sh   <= {sh[DW-2:0], samp};
        bits <= last ? '0 : bits + CW'(1);
        if (last) begin
          rxbuf <= {sh[DW-2:0], samp};
          busy  <= 1'b0;
        end
      end else if (!is_master && !ss_low) begin
        bits <= '0;
      end

      if (!is_master) begin
        busy  <= 1'b0;
        sck_q <= 1'b0;
      end

      if (last)     done_flag <= 1'b1;
      else if (clr) done_flag <= 1'b0;

      if (wr_en && active) wcol_flag <= 1'b1;
      else if (clr)        wcol_flag <= 1'b0;

      if (last || clr)             armed <= 1'b0;
      else if (stat_rd && done_flag) armed <= 1'b1;
    end
  end

  assign rd_data = rxbuf;
  assign sck_o   = sck_q;
  assign sck_oe  = is_master;
  assign mosi_o  = sh[DW-1];
  assign miso_o  = sh[DW-1];
  assign miso_oe = !is_master && ss_low;
endmodule

// File: rtl/spi_dual_role_chk.sv
module spi_dual_role_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          is_master,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic          done_flag,
  input logic          wcol_flag,
  input logic          sck_o,
  input logic          mosi_o
);
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_flag && !rd_en |=> done_flag); // R7
  AST_WCOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wcol_flag && !rd_en |=> wcol_flag); // R8
  AST_BUF_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> done_flag); // R6
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    is_master && sck_o && $past(sck_o) |-> $stable(mosi_o)); // R4
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    is_master && $rose(done_flag) |-> $fell(sck_o)); // R5
endmodule

bind spi_dual_role spi_dual_role_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .is_master(is_master), .rd_en(rd_en),
  .rd_data(rd_data), .done_flag(done_flag), .wcol_flag(wcol_flag),
  .sck_o(sck_o), .mosi_o(mosi_o)
);

// File: tb/spi_dual_role_tb.sv
module spi_dual_role_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic is_master = 1'b1, wr_en = 1'b0, stat_rd = 1'b0, rd_en = 1'b0;
  logic [2:0] div_sel = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic sck_i = 1'b0, ss_n = 1'b1, mosi_i = 1'b0, miso_i = 1'b0;
  logic [7:0] rd_data;
  logic done_flag, wcol_flag, sck_o, sck_oe, mosi_o, miso_o, miso_oe;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_dual_role u_dut (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .div_sel(div_sel),
    .wr_en(wr_en), .wr_data(wr_data), .stat_rd(stat_rd), .rd_en(rd_en),
    .rd_data(rd_data), .done_flag(done_flag), .wcol_flag(wcol_flag),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .ss_n(ss_n),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .miso_i(miso_i), .miso_o(miso_o),
    .miso_oe(miso_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int phase_len(input int ds);
    return 1 << ((ds > 4) ? 4 : ds);
  endfunction

  task automatic pulse_wr(input logic [7:0] d);
    wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic clear_seq();
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    rd_en = 1'b1;   @(negedge clk); rd_en = 1'b0;
  endtask

  // Bench acts as slave; optionally tries a write during the byte.
  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] sb, input int ds,
                             input bit collide);
    logic [7:0] sreg, mcap;
    int falls, rises, t, last_rise, per, waited;
    bit prev, per_ok;
    is_master = 1'b1; div_sel = 3'(ds);
    sreg = sb; miso_i = sreg[7]; mcap = 8'h00;
    falls = 0; rises = 0; t = 0; last_rise = 0; per_ok = 1; per = 2 * phase_len(ds);
    pulse_wr(tx);
    chk(mosi_o == tx[7], "R2 msb on mosi after load", mosi_o, tx[7]);
    prev = sck_o; waited = 0;
    while (falls < 8 && waited < 2000) begin
      if (collide && t == 3) begin wr_data = ~tx; wr_en = 1'b1; end
      else wr_en = 1'b0;
      if (sck_o && !prev) begin
        mcap = {mcap[6:0], mosi_o};
        if (rises == 0) begin
          if (t != phase_len(ds)) per_ok = 0;
        end else if (t - last_rise != per) per_ok = 0;
        last_rise = t; rises++;
      end
      if (!sck_o && prev) begin
        falls++;
        if (falls == 8)
          chk(done_flag == 1'b1, "R5 flag set on eighth fall", done_flag, 1);
        else
          chk(done_flag == 1'b0, "R5 flag not early", done_flag, 0);
        sreg = {sreg[6:0], 1'b0}; miso_i = sreg[7];
      end
      prev = sck_o;
      @(negedge clk); t++; waited++;
    end
    wr_en = 1'b0;
    chk(per_ok, "R3 sck phase timing", ds, per);
    chk(mcap == tx, "R4 byte seen on mosi", mcap, tx);
    chk(rd_data == sb, "R5 received byte in buffer", rd_data, sb);
    chk(sck_o == 1'b0, "R3 sck idles low", sck_o, 0);
    if (collide) chk(wcol_flag == 1'b1, "R8 collision flagged", wcol_flag, 1);
  endtask

  // Bench acts as master for slave mode.
  task automatic slave_xfer(input logic [7:0] mb, input int half, input int nbits,
                            output logic [7:0] cap);
    cap = 8'h00;
    ss_n = 1'b0; repeat (half) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi_i = mb[7-i];
      repeat (half) @(negedge clk);
      cap = {cap[6:0], miso_o}; sck_i = 1'b1;
      repeat (half) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (6) @(negedge clk);
    ss_n = 1'b1; repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] cap, tx, sb, keep;
    int ds, hf;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1; @(negedge clk);

    chk(done_flag == 0 && wcol_flag == 0, "R5 reset flags clear", {done_flag, wcol_flag}, 0);
    chk(rd_data == 8'h00, "R6 reset buffer zero", rd_data, 0);
    chk(sck_oe == 1'b1 && sck_o == 1'b0, "R1 master drives idle sck", {sck_oe, sck_o}, 2);

    master_xfer(8'hA5, 8'h3C, 0, 0);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    chk(done_flag == 1'b1, "R7 data read alone keeps flag", done_flag, 1);
    clear_seq();
    chk(done_flag == 1'b0, "R7 status then data clears", done_flag, 0);
    repeat (20) @(negedge clk);
    chk(rd_data == 8'h3C, "R6 buffer holds after clear", rd_data, 8'h3C);

    master_xfer(8'h81, 8'h7E, 2, 1);
    clear_seq();
    chk(wcol_flag == 1'b0, "R8 collision cleared by sequence", wcol_flag, 0);

    master_xfer(8'hFF, 8'h00, 7, 0);
    clear_seq();

    for (int k = 0; k < 6; k++) begin
      tx = 8'($urandom); sb = 8'($urandom); ds = int'($urandom % 5);
      master_xfer(tx, sb, ds, 0);
      clear_seq();
    end

    is_master = 1'b0; @(negedge clk);
    chk(sck_oe == 1'b0, "R1 slave does not drive sck", sck_oe, 0);

    keep = rd_data;
    for (int i = 0; i < 8; i++) begin
      sck_i = 1'b1; repeat (4) @(negedge clk);
      sck_i = 1'b0; repeat (4) @(negedge clk);
    end
    chk(done_flag == 1'b0, "R9 sck ignored while deselected", done_flag, 0);
    chk(rd_data == keep, "R9 buffer unchanged while deselected", rd_data, keep);

    pulse_wr(8'hC3);
    slave_xfer(8'h5A, 4, 8, cap);
    chk(done_flag == 1'b1, "R9 slave completes byte", done_flag, 1);
    chk(rd_data == 8'h5A, "R9 slave received byte", rd_data, 8'h5A);
    chk(cap == 8'hC3, "R4 slave sent byte msb first", cap, 8'hC3);
    clear_seq();

    keep = rd_data;
    pulse_wr(8'h96);
    slave_xfer(8'h11, 5, 3, cap);
    chk(done_flag == 1'b0, "R10 abort leaves flag", done_flag, 0);
    chk(rd_data == keep, "R10 abort leaves buffer", rd_data, keep);
    pulse_wr(8'h69);
    slave_xfer(8'hE7, 5, 8, cap);
    chk(rd_data == 8'hE7, "R10 fresh count after abort", rd_data, 8'hE7);
    chk(cap == 8'h69, "R10 fresh byte sent after abort", cap, 8'h69);
    clear_seq();

    pulse_wr(8'h0F);
    ss_n = 1'b0; repeat (4) @(negedge clk);
    pulse_wr(8'hF0);
    chk(wcol_flag == 1'b1, "R8 slave write while selected", wcol_flag, 1);
    ss_n = 1'b1; repeat (4) @(negedge clk);
    slave_xfer(8'h24, 4, 8, cap);
    chk(cap == 8'h0F, "R8 ignored write left byte", cap, 8'h0F);
    clear_seq();

    for (int k = 0; k < 4; k++) begin
      tx = 8'($urandom); sb = 8'($urandom); hf = 4 + int'($urandom % 3);
      pulse_wr(sb);
      slave_xfer(tx, hf, 8, cap);
      chk(rd_data == tx, "R9 random slave receive", rd_data, tx);
      chk(cap == sb, "R4 random slave send", cap, sb);
      clear_seq();
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule